// File: doc/BRIEF.md
# Per-Channel Burst Count Fault Monitor

This block watches the burst count produced for each of ten sensing channels and decides whether that count is plausible. Each time the acquisition engine finishes a burst, it presents a result with a valid strobe, a channel index, a 12-bit count that saturates at full scale, and an overflow indication. The block compares the count against a programmable 8-bit floor and a fixed ceiling. A channel that fails either check has its fault flag set, and the flag stays set.

A count below the floor also withdraws the channel's acquisition enable, so the scan sequencer stops bursting on a channel whose sense circuit looks shorted or broken. A floor of zero turns off the floor check and also turns off the self-disable. Overflow still raises the fault flag in that case, but the channel stays enabled. A per-channel recalibrate pulse clears the flag and restores the enable. If a new fault arrives on the same channel in the same cycle as the pulse, the fault wins.

Top module: `burst_fault_monitor`

## Requirements
- R1: After reset every bit of `acq_en` is 1 and every bit of `err_flags` is 0.
- R2: A valid result whose count is strictly below a nonzero `low_limit` sets that channel's flag and clears its enable on the next clock edge. A count equal to the limit is not a fault.
- R3: When `low_limit` is 0, no count value raises a fault. An overflow result in that state sets the flag but does not clear the enable.
- R4: A valid result with `res_ovf` high is a fault on the indexed channel (the count is above the fixed ceiling of 4095). With a nonzero `low_limit`, it also clears the enable.
- R5: A full-scale count of 4095 with `res_ovf` low is not a fault.
- R6: Only the channel selected by `res_chan` (binary index 0 to 9) is updated, and only while `res_valid` is high. An index of 10 to 15 changes nothing.
- R7: Flags and disables are latched. A later in-range result on a faulted channel neither clears its flag nor re-enables it.
- R8: A pulse on `recal[i]` clears `err_flags[i]` and sets `acq_en[i]` one cycle later, without touching any other channel.
- R9: If a fault on channel i and `recal[i]` occur in the same cycle, the fault takes precedence: the flag stays set and the enable stays cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| res_valid | input | 1 | A burst result is present this cycle |
| res_chan | input | 4 | Channel index of the result |
| res_count | input | 12 | Measured burst count, saturating at 4095 |
| res_ovf | input | 1 | Count ran past the ceiling |
| low_limit | input | 8 | Programmable lower count limit; 0 disables it |
| recal | input | 10 | Per-channel recalibrate pulses |
| err_flags | output | 10 | Latched fault flag per channel |
| acq_en | output | 10 | Acquisition enable per channel |

## Verification
The assertions assume that the inputs carry known values on every clock edge once reset is released. They also assume that `res_chan` and `low_limit` are meaningful only together with `res_valid`. They do not assume that indices stay within range: an index outside 0 to 9 must simply leave the state untouched. The bench changes every input half a cycle away from the sampling edge and keeps every input at a defined value throughout. It deliberately drives out-of-range indices and puts results next to recalibrate pulses on the same channel and on other channels, so the precedence and isolation properties are exercised under the stated assumptions.

// File: rtl/burst_fault_monitor.sv
module burst_fault_monitor #(
  parameter int NCH = 10,
  parameter int CW  = 12,
  parameter int LW  = 8,
  localparam int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           res_valid,
  input  logic [CHW-1:0] res_chan,
  input  logic [CW-1:0]  res_count,
  input  logic           res_ovf,
  input  logic [LW-1:0]  low_limit,
  input  logic [NCH-1:0] recal,
  output logic [NCH-1:0] err_flags,
  output logic [NCH-1:0] acq_en
);

  logic lim_on, lo_err, any_err, dis_req;

  assign lim_on  = |low_limit;
  assign lo_err  = lim_on && (res_count < CW'(low_limit));
  assign any_err = lo_err || res_ovf;
  assign dis_req = lim_on && any_err;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic hit;
    assign hit = res_valid && (int'(res_chan) == i);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        err_flags[i] <= 1'b0;
        acq_en[i]    <= 1'b1;
      end else begin
        err_flags[i] <= (hit && any_err) || (err_flags[i] && !recal[i]);
        acq_en[i]    <= !(hit && dis_req) && (acq_en[i] || recal[i]);
      end
    end
  end

endmodule

// File: rtl/burst_fault_monitor_chk.sv
module burst_fault_monitor_chk #(
  parameter int NCH = 10,
  parameter int CW  = 12,
  parameter int LW  = 8,
  localparam int CHW = $clog2(NCH)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           res_valid,
  input logic [CHW-1:0] res_chan,
  input logic [CW-1:0]  res_count,
  input logic           res_ovf,
  input logic [LW-1:0]  low_limit,
  input logic [NCH-1:0] recal,
  input logic [NCH-1:0] err_flags,
  input logic [NCH-1:0] acq_en
);

  assert_low_fault_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && int'(res_chan) < NCH && low_limit != '0 && res_count < CW'(low_limit))
    |=> (err_flags[$past(res_chan)] && !acq_en[$past(res_chan)]));

  assert_zero_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (low_limit == '0 && !res_ovf) |=> ((err_flags & ~$past(err_flags)) == '0));

  assert_ovf_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && int'(res_chan) < NCH && res_ovf) |=> err_flags[$past(res_chan)]);

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!res_valid && recal == '0) |=> ($stable(err_flags) && $stable(acq_en)));

  assert_flag_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(err_flags) & ~err_flags & ~$past(recal)) == '0));

  assert_enable_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~$past(acq_en) & acq_en & ~$past(recal)) == '0));

  assert_drop_needs_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(acq_en) & ~acq_en & ~err_flags) == '0));

endmodule

bind burst_fault_monitor burst_fault_monitor_chk #(.NCH(NCH), .CW(CW), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_chan(res_chan),
  .res_count(res_count), .res_ovf(res_ovf), .low_limit(low_limit), .recal(recal),
  .err_flags(err_flags), .acq_en(acq_en)
);

// File: tb/burst_fault_monitor_bench.sv
module burst_fault_monitor_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       res_valid = 1'b0;
  logic [3:0] res_chan = '0;
  logic [11:0] res_count = '0;
  logic       res_ovf = 1'b0;
  logic [7:0] low_limit = '0;
  logic [9:0] recal = '0;
  logic [9:0] err_flags, acq_en;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  burst_fault_monitor u_burst_fault_monitor (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_chan(res_chan),
    .res_count(res_count), .res_ovf(res_ovf), .low_limit(low_limit), .recal(recal),
    .err_flags(err_flags), .acq_en(acq_en)
  );

  // {valid, chan[3:0], count[11:0], ovf, limit[7:0], recal[9:0], exp_err[9:0], exp_en[9:0]}
  localparam int NV = 14;
  localparam logic [55:0] TBL [NV] = '{
    {1'b1, 4'd0,  12'd50,   1'b0, 8'd50,  10'h000, 10'h000, 10'h3FF}, // R2 equal
    {1'b1, 4'd0,  12'd49,   1'b0, 8'd50,  10'h000, 10'h001, 10'h3FE}, // R2 below
    {1'b1, 4'd1,  12'd0,    1'b0, 8'd0,   10'h000, 10'h001, 10'h3FE}, // R3
    {1'b1, 4'd2,  12'd4095, 1'b0, 8'd3,   10'h000, 10'h001, 10'h3FE}, // R5
    {1'b1, 4'd3,  12'd100,  1'b1, 8'd3,   10'h000, 10'h009, 10'h3F6}, // R4
    {1'b1, 4'd4,  12'd100,  1'b1, 8'd0,   10'h000, 10'h019, 10'h3F6}, // R3 ovf
    {1'b1, 4'd12, 12'd0,    1'b0, 8'd100, 10'h000, 10'h019, 10'h3F6}, // R6 index
    {1'b0, 4'd5,  12'd0,    1'b0, 8'd100, 10'h000, 10'h019, 10'h3F6}, // R6 no valid
    {1'b1, 4'd0,  12'd200,  1'b0, 8'd50,  10'h000, 10'h019, 10'h3F6}, // R7
    {1'b0, 4'd0,  12'd0,    1'b0, 8'd50,  10'h001, 10'h018, 10'h3F7}, // R8
    {1'b1, 4'd3,  12'd1,    1'b0, 8'd3,   10'h008, 10'h018, 10'h3F7}, // R9
    {1'b0, 4'd0,  12'd0,    1'b0, 8'd3,   10'h010, 10'h008, 10'h3F7}, // R8
    {1'b1, 4'd9,  12'd2,    1'b0, 8'd255, 10'h000, 10'h208, 10'h1F7}, // R2
    {1'b0, 4'd0,  12'd0,    1'b0, 8'd3,   10'h208, 10'h000, 10'h3FF}  // R8
  };
  localparam string TAG [NV] = '{"R2","R2","R3","R5","R4","R3","R6","R6",
                                 "R7","R8","R9","R8","R2","R8"};

  task automatic check(input string tag, input logic [9:0] exp_err, input logic [9:0] exp_en);
    checks++;
    if (err_flags !== exp_err || acq_en !== exp_en) begin
      fails++;
      $display("FAIL %s: err_flags=%h acq_en=%h expected err_flags=%h acq_en=%h",
               tag, err_flags, acq_en, exp_err, exp_en);
    end
  endtask

  task automatic apply(input logic v, input logic [3:0] ch, input logic [11:0] cnt,
                       input logic ovf, input logic [7:0] lim, input logic [9:0] rc);
    @(negedge clk);
    res_valid = v; res_chan = ch; res_count = cnt; res_ovf = ovf;
    low_limit = lim; recal = rc;
    @(negedge clk);
    res_valid = 1'b0; recal = '0; res_ovf = 1'b0;
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    do_reset();
    check("R1", 10'h000, 10'h3FF);

    for (int k = 0; k < NV; k++) begin
      apply(TBL[k][55], TBL[k][54:51], TBL[k][50:39], TBL[k][38],
            TBL[k][37:30], TBL[k][29:20]);
      check(TAG[k], TBL[k][19:10], TBL[k][9:0]);
    end

    // R6/R8: fault on ch6 while ch7 is recalibrated, channels isolated
    apply(1'b1, 4'd6, 12'd10, 1'b0, 8'd20, 10'h080);
    check("R6", 10'h040, 10'h3BF);
    // R4: overflow with nonzero limit on ch8, count value irrelevant
    apply(1'b1, 4'd8, 12'd4095, 1'b1, 8'd1, 10'h000);
    check("R4", 10'h140, 10'h2BF);
    // R2: limit 1, count 0 faults; count 1 does not
    apply(1'b1, 4'd1, 12'd1, 1'b0, 8'd1, 10'h000);
    check("R2", 10'h140, 10'h2BF);
    apply(1'b1, 4'd1, 12'd0, 1'b0, 8'd1, 10'h000);
    check("R2", 10'h142, 10'h2BD);
    // R1: reset clears the accumulated state
    do_reset();
    check("R1", 10'h000, 10'h3FF);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule